// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between a statically scheduled pipeline and a memory whose response time varies from load to load. A software-written latency register holds the number of cycles the compiled schedule assumes between issuing a load and using its result. Each accepted load gets a slot and a countdown. Data that memory returns ahead of time is parked in the slot. The value is handed to the pipeline's writeback port in exactly the cycle the schedule expects.

When a load falls due and its data has not arrived, the block raises a stall that freezes the pipeline. The stall also freezes every other countdown, so later loads keep their spacing relative to the stalled one. Up to eight loads may be outstanding. Memory answers by tag in any order, and issue is refused whenever every slot is taken or the pipeline is stalled.

Top module: `fixlat_load_buf`

## Requirements
- R1: After reset, wb_valid and stall are 0, iss_ready is 1 and iss_tag is 0.
- R2: The latency register resets to 4. A write (lat_wr_en=1) stores lat_wr_val, and a written value of 0 behaves as 1.
- R3: A load accepted in cycle c with latency L, whose response was accepted in a cycle before c+L, appears on wb_valid/wb_dest/wb_data in cycle c+L, provided no stall intervenes.
- R4: Responses are matched to loads by rsp_tag and may arrive in any order. Each load delivers its own data.
- R5: If a due load has no data, stall is 1 and wb_valid is 0 from its due cycle. The value is delivered, with stall 0, in the cycle after its response is accepted.
- R6: Each stalled cycle delays the due cycle of every other outstanding load by exactly one cycle.
- R7: A latency write takes effect only for loads accepted after the clock edge that stores it. A load issued in the same cycle as the write uses the old value.
- R8: iss_tag is the lowest-numbered free slot (0 to 7). It is the tag that memory must return on rsp_tag.
- R9: With 8 loads outstanding, iss_ready is 0 and iss_valid is ignored.
- R10: While stall is 1, iss_ready is 0.
- R11: When two loads fall due in the same cycle, the lower tag is delivered with stall 1. The other is delivered in the next cycle.
- R12: A response whose tag has no outstanding load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr_en | input | 1 | Latency register write strobe |
| lat_wr_val | input | 4 | New load latency in cycles |
| iss_valid | input | 1 | Pipeline issues a load this cycle |
| iss_dest | input | 5 | Destination register of the issued load |
| iss_ready | output | 1 | A load can be accepted this cycle |
| iss_tag | output | 3 | Tag assigned to the load issued this cycle |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | 3 | Tag of the response |
| rsp_data | input | 32 | Response data |
| wb_valid | output | 1 | Load value delivered this cycle |
| wb_dest | output | 5 | Destination register of delivered value |
| wb_data | output | 32 | Delivered value |
| stall | output | 1 | Pipeline must hold |

## Verification
The delivery path is tried with several patterns. Early responses in issue order and in reverse order test that data is held until due and matched by tag. A response that misses its due cycle tests the stall, and the two cycles it adds to a younger load test the frozen countdowns. A latency change between back-to-back issues, a deliberate double due cycle and a latency of zero test which value a load captures and how collisions serialize. A full burst of eight loads, plus a stray response, tests tag allocation, refusal at capacity and that unmatched data leaves no trace.

// File: rtl/fixlat_pkg.sv
package fixlat_pkg;
    localparam int SLOTS   = 8;
    localparam int TAG_W   = $clog2(SLOTS);
    localparam int DATA_W  = 32;
    localparam int DEST_W  = 5;
    localparam int LAT_W   = 4;

    // request captured by a slot when a load is accepted
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [LAT_W-1:0]  cnt;
    } alloc_t;

    // state a slot presents to the selection logic
    typedef struct packed {
        logic              busy;
        logic              ready;
        logic              due;
        logic [LAT_W-1:0]  cnt;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } slot_view_t;

    // a latency of zero is treated as one cycle
    function automatic logic [LAT_W-1:0] lat_clamp(input logic [LAT_W-1:0] v);
        return (v == '0) ? LAT_W'(1) : v;
    endfunction
endpackage

// File: rtl/fixlat_mlr.sv
module fixlat_mlr
    import fixlat_pkg::*;
#(
    parameter int DEF_LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] wr_val,
    output logic [LAT_W-1:0] lat_q
);
    always_ff @(posedge clk) begin
        if (rst)        lat_q <= lat_clamp(LAT_W'(DEF_LAT));
        else if (wr_en) lat_q <= lat_clamp(wr_val);
    end
endmodule

// File: rtl/fixlat_pick.sv
module fixlat_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/fixlat_slot.sv
module fixlat_slot
    import fixlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  alloc_t            alloc_in,
    input  logic              rsp_hit,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              hold,
    input  logic              release_i,
    output slot_view_t        view
);
    logic              busy_q, ready_q;
    logic [LAT_W-1:0]  cnt_q;
    logic [DEST_W-1:0] dest_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            cnt_q   <= '0;
            dest_q  <= '0;
            data_q  <= '0;
        end else if (release_i) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (alloc) begin
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
            cnt_q   <= alloc_in.cnt;
            dest_q  <= alloc_in.dest;
        end else if (busy_q) begin
            if (rsp_hit && !ready_q) begin
                ready_q <= 1'b1;
                data_q  <= rsp_data;
            end
            if (!hold && cnt_q != '0)
                cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    always_comb begin
        view.busy  = busy_q;
        view.ready = ready_q;
        view.due   = busy_q && (cnt_q == '0);
        view.cnt   = cnt_q;
        view.dest  = dest_q;
        view.data  = data_q;
    end
endmodule

// File: rtl/fixlat_load_buf.sv
module fixlat_load_buf
    import fixlat_pkg::*;
#(
    parameter int NSLOT   = fixlat_pkg::SLOTS,
    parameter int DEF_LAT = 4,
    localparam int TW     = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_wr_en,
    input  logic [LAT_W-1:0]  lat_wr_val,
    input  logic              iss_valid,
    input  logic [DEST_W-1:0] iss_dest,
    output logic              iss_ready,
    output logic [TW-1:0]     iss_tag,
    input  logic              rsp_valid,
    input  logic [TW-1:0]     rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [DEST_W-1:0] wb_dest,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);
    logic [LAT_W-1:0]            lat_q;
    slot_view_t                  view [NSLOT];
    logic [NSLOT-1:0]            slot_busy, slot_due, slot_ready;
    logic [NSLOT-1:0][LAT_W-1:0] slot_cnt;
    logic [NSLOT-1:0]            free_gnt, dlv_gnt;
    logic                        free_any, dlv_any;
    logic [TW-1:0]               free_idx, dlv_idx;
    logic                        iss_fire;
    alloc_t                      alloc_req;

    fixlat_mlr #(.DEF_LAT(DEF_LAT)) mlr_i (
        .clk(clk), .rst(rst), .wr_en(lat_wr_en), .wr_val(lat_wr_val), .lat_q(lat_q)
    );

    always_comb begin
        alloc_req.dest = iss_dest;
        alloc_req.cnt  = lat_q - LAT_W'(1);
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        fixlat_slot slot_i (
            .clk      (clk),
            .rst      (rst),
            .alloc    (iss_fire && free_gnt[i]),
            .alloc_in (alloc_req),
            .rsp_hit  (rsp_valid && (rsp_tag == TW'(i))),
            .rsp_data (rsp_data),
            .hold     (stall),
            .release_i(dlv_gnt[i]),
            .view     (view[i])
        );
        assign slot_busy[i]  = view[i].busy;
        assign slot_due[i]   = view[i].due;
        assign slot_ready[i] = view[i].ready;
        assign slot_cnt[i]   = view[i].cnt;
    end

    fixlat_pick #(.N(NSLOT)) free_pick_i (
        .req(~slot_busy), .gnt(free_gnt), .any(free_any), .idx(free_idx)
    );

    fixlat_pick #(.N(NSLOT)) dlv_pick_i (
        .req(slot_due & slot_ready), .gnt(dlv_gnt), .any(dlv_any), .idx(dlv_idx)
    );

    always_comb begin
        stall     = |(slot_due & ~dlv_gnt);
        iss_ready = free_any && !stall;
        iss_tag   = free_idx;
        iss_fire  = iss_valid && iss_ready;
        wb_valid  = dlv_any;
        wb_dest   = view[dlv_idx].dest;
        wb_data   = view[dlv_idx].data;
    end
endmodule

// File: rtl/fixlat_chk.sv
module fixlat_chk #(
    parameter int NSLOT = 8,
    parameter int CW    = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  iss_ready,
    input logic                  stall,
    input logic                  wb_valid,
    input logic [NSLOT-1:0]      busy,
    input logic [NSLOT-1:0]      due,
    input logic [NSLOT-1:0]      ready,
    input logic [NSLOT-1:0]      dlv,
    input logic [NSLOT-1:0][CW-1:0] cnt
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wb_valid && !stall && busy == '0));            // R1
    AST_READY_DUE_SERVED: assert property (@(posedge clk) disable iff (rst)
        (|(due & ready)) |-> wb_valid);                                // R3
    AST_DUE_SERVED_OR_HELD: assert property (@(posedge clk) disable iff (rst)
        (|due) |-> (wb_valid || stall));                               // R5
    AST_FULL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (&busy) |-> !iss_ready);                                       // R9
    AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        stall |-> !iss_ready);                                         // R10

    for (genvar i = 0; i < NSLOT; i++) begin : g_frz
        AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
            (stall && busy[i] && !dlv[i]) |=> $stable(cnt[i]));        // R6
    end
endmodule

bind fixlat_load_buf fixlat_chk #(.NSLOT(NSLOT), .CW(fixlat_pkg::LAT_W)) chk_i (
    .clk(clk), .rst(rst), .iss_ready(iss_ready), .stall(stall), .wb_valid(wb_valid),
    .busy(slot_busy), .due(slot_due), .ready(slot_ready), .dlv(dlv_gnt), .cnt(slot_cnt)
);

// File: tb/fixlat_load_buf_tb_top.sv
module fixlat_load_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lat_wr_en = 1'b0;
    logic [3:0]  lat_wr_val = '0;
    logic        iss_valid = 1'b0;
    logic [4:0]  iss_dest = '0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_tag = '0;
    logic [31:0] rsp_data = '0;
    logic        wb_valid;
    logic [4:0]  wb_dest;
    logic [31:0] wb_data;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fixlat_load_buf dut_i (
        .clk(clk), .rst(rst), .lat_wr_en(lat_wr_en), .lat_wr_val(lat_wr_val),
        .iss_valid(iss_valid), .iss_dest(iss_dest), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data), .stall(stall)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_wb(input string req, input logic [4:0] d, input logic [31:0] v);
        chk(req, "wb_valid", {31'b0, wb_valid}, 32'd1);
        chk(req, "wb_dest", {27'b0, wb_dest}, {27'b0, d});
        chk(req, "wb_data", wb_data, v);
    endtask

    task automatic set_lat(input logic [3:0] l);
        lat_wr_en = 1'b1; lat_wr_val = l;
        step();
        lat_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "wb_valid", {31'b0, wb_valid}, 0);
        chk("R1", "stall", {31'b0, stall}, 0);
        chk("R1", "iss_ready", {31'b0, iss_ready}, 1);
        chk("R1", "iss_tag", {29'b0, iss_tag}, 0);
    endtask

    // default latency 4, early response
    task automatic t_basic();
        iss_valid = 1; iss_dest = 5;
        step();                                    // c+1
        iss_valid = 0; rsp_valid = 1; rsp_tag = 0; rsp_data = 32'hAA;
        step();                                    // c+2
        rsp_valid = 0;
        step();                                    // c+3
        chk("R3", "no early wb", {31'b0, wb_valid}, 0);
        step();                                    // c+4
        chk_wb("R2_R3", 5, 32'hAA);
        chk("R3", "stall", {31'b0, stall}, 0);
        step();
        chk("R3", "single wb", {31'b0, wb_valid}, 0);
    endtask

    // latency 0 acts as 1: data cannot be early, so one stall
    task automatic t_zero_lat();
        set_lat(0);
        iss_valid = 1; iss_dest = 7;
        step();                                    // c+1 due
        iss_valid = 0;
        chk("R2", "stall at lat 1", {31'b0, stall}, 1);
        chk("R5", "no wb w/o data", {31'b0, wb_valid}, 0);
        rsp_valid = 1; rsp_tag = 0; rsp_data = 32'h11;
        step();                                    // c+2
        rsp_valid = 0;
        chk_wb("R5", 7, 32'h11);
        chk("R5", "stall clears", {31'b0, stall}, 0);
        step();
    endtask

    // reverse-order responses
    task automatic t_ooo();
        set_lat(6);
        iss_valid = 1; iss_dest = 1; step();
        iss_dest = 2; step();
        iss_dest = 3; step();                      // c+3
        iss_valid = 0; rsp_valid = 1; rsp_tag = 2; rsp_data = 32'hC3; step();
        rsp_tag = 0; rsp_data = 32'hA1; step();
        rsp_tag = 1; rsp_data = 32'hB2; step();    // c+6
        rsp_valid = 0;
        chk_wb("R4", 1, 32'hA1); step();
        chk_wb("R4", 2, 32'hB2); step();
        chk_wb("R4", 3, 32'hC3); step();
        chk("R4", "drained", {31'b0, wb_valid}, 0);
    endtask

    // late data stalls and shifts the younger load
    task automatic t_late();
        set_lat(3);
        iss_valid = 1; iss_dest = 10; step();
        iss_dest = 11; step();                     // c+2
        iss_valid = 0; rsp_valid = 1; rsp_tag = 1; rsp_data = 32'hB; step();
        rsp_valid = 0;                             // c+3
        chk("R5", "stall", {31'b0, stall}, 1);
        chk("R5", "no wb", {31'b0, wb_valid}, 0);
        chk("R10", "iss_ready in stall", {31'b0, iss_ready}, 0);
        step();                                    // c+4
        chk("R5", "stall held", {31'b0, stall}, 1);
        chk("R6", "younger held", {31'b0, wb_valid}, 0);
        rsp_valid = 1; rsp_tag = 0; rsp_data = 32'hA; step();
        rsp_valid = 0;                             // c+5
        chk_wb("R5", 10, 32'hA);
        chk("R5", "stall off", {31'b0, stall}, 0);
        step();                                    // c+6
        chk_wb("R6", 11, 32'hB);
        step();
        chk("R6", "drained", {31'b0, wb_valid}, 0);
    endtask

    // latency change between back-to-back issues
    task automatic t_lat_change();
        set_lat(5);
        iss_valid = 1; iss_dest = 20; step();      // c+1
        iss_dest = 21; lat_wr_en = 1; lat_wr_val = 2;
        rsp_valid = 1; rsp_tag = 0; rsp_data = 32'h20; step();
        lat_wr_en = 0; iss_dest = 22; rsp_tag = 1; rsp_data = 32'h21; step();
        iss_valid = 0; rsp_tag = 2; rsp_data = 32'h22; step();   // c+4
        rsp_valid = 0;
        chk_wb("R7", 22, 32'h22); step();
        chk_wb("R7", 20, 32'h20); step();
        chk_wb("R7", 21, 32'h21); step();
        chk("R7", "drained", {31'b0, wb_valid}, 0);
    endtask

    // two loads fall due together
    task automatic t_collide();
        set_lat(3);
        iss_valid = 1; iss_dest = 1; lat_wr_en = 1; lat_wr_val = 2; step();
        lat_wr_en = 0; iss_dest = 2; rsp_valid = 1; rsp_tag = 0; rsp_data = 32'h51; step();
        iss_valid = 0; rsp_tag = 1; rsp_data = 32'h52; step();   // c+3
        rsp_valid = 0;
        chk_wb("R11", 1, 32'h51);
        chk("R11", "stall on collision", {31'b0, stall}, 1);
        step();
        chk_wb("R11", 2, 32'h52);
        chk("R11", "stall off", {31'b0, stall}, 0);
        step();
        chk("R11", "drained", {31'b0, wb_valid}, 0);
    endtask

    // response to an idle tag leaves no data behind
    task automatic t_stray();
        set_lat(2);
        rsp_valid = 1; rsp_tag = 0; rsp_data = 32'hBAD; step();
        rsp_valid = 0; iss_valid = 1; iss_dest = 9; step();      // c+2
        iss_valid = 0;
        chk("R12", "not due yet", {31'b0, stall}, 0);
        step();                                                  // c+3 due
        chk("R12", "stray not kept", {31'b0, stall}, 1);
        chk("R12", "no wb", {31'b0, wb_valid}, 0);
        rsp_valid = 1; rsp_data = 32'h77; step();
        rsp_valid = 0;
        chk_wb("R12", 9, 32'h77);
        step();
    endtask

    // fill all slots, refuse a ninth, drain in order
    task automatic t_full();
        set_lat(15);
        for (int k = 0; k < 8; k++) begin
            chk("R8", "iss_ready", {31'b0, iss_ready}, 1);
            chk("R8", "iss_tag", {29'b0, iss_tag}, k);
            iss_valid = 1; iss_dest = 5'(k);
            step();
        end
        iss_dest = 31;                                           // c+8
        chk("R9", "full", {31'b0, iss_ready}, 0);
        for (int k = 0; k < 8; k++) begin
            rsp_valid = 1; rsp_tag = 3'(k); rsp_data = 32'(100 + k);
            if (k == 7) chk_wb("R9", 0, 32'd100);
            step();
            iss_valid = 0;
        end
        rsp_valid = 0;                                           // c+16
        for (int j = 1; j < 8; j++) begin
            chk_wb("R9", 5'(j), 32'(100 + j));
            step();
        end
        for (int j = 0; j < 3; j++) begin
            chk("R9", "ninth ignored", {31'b0, wb_valid}, 0);
            step();
        end
        chk("R8", "tag after drain", {29'b0, iss_tag}, 0);
        chk("R8", "ready after drain", {31'b0, iss_ready}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_basic();
        t_zero_lat();
        t_ooo();
        t_late();
        t_lat_change();
        t_collide();
        t_stray();
        t_full();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL all-requirements watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule